// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Write Timing Generator

This block sequences a single write access to an external device whose address and data travel over one shared bus. When it accepts a start request it captures the address, up to `MAX_BEATS` write data words, the beat count and every timing field. It then runs a cycle counter from 0 and decodes the bus strobes and the shared bus value from that counter.

The bus carries the upper half of the address first, then the lower half. The phase change is marked by the first output-enable window closing. The address phase ends when write enable asserts, and the lower half stays on the bus until the first data beat. Data beats start at their own programmable time, and further beats follow at a programmable interval. The last beat stays on the bus until the access ends. Between accesses the bus keeps the last value it carried.

All strobes are active low. Each strobe is asserted in counter cycles `c` where `on <= c < off`, using that strobe's captured fields. A window whose on time is not below its off time never asserts.

Top module: `awm_wr_timer`

## Requirements
- R1: A start request seen while idle begins an access on the next clock edge. Cycle 0 follows that edge. `busy` is high for exactly `cyc_time` cycles, or for 1 cycle when `cyc_time` is 0.
- R2: A start request during an access is ignored. Holding `start` high for the whole access does not lengthen it.
- R3: `cs_n` is low, `dir_o` is high and `bus_oe` is high in exactly the cycles where `busy` is high.
- R4: `adv_n` is low in cycle c exactly when `adv1_on <= c < adv1_off` or `adv2_on <= c < adv2_off`.
- R5: `oe_n` is low in cycle c exactly when `oe1_on <= c < oe1_off` or `oe2_on <= c < oe2_off`.
- R6: `we_n` is low in cycle c exactly when `we_on <= c < we_off`. The on field is 4 bits wide and the off field is 5 bits wide.
- R7: If c < `data_on`, the bus carries an address half. It carries `addr[31:16]` when c < `oe1_off` and c < `we_on`. Otherwise it carries `addr[15:0]`.
- R8: Let g be `beat_gap`, with 0 treated as 1. For c >= `data_on`, the bus carries beat k, which is `wr_data[16k+15:16k]`. Here k is the largest index with k <= `beat_cnt` and c >= `data_on + k*g`. `beat_cnt` holds the number of beats minus one. The last beat reached is held until the access ends.
- R9: While idle, `bus_o` keeps the last value driven during the previous access, or 0 after reset.
- R10: The address, data, beat count and every timing field are captured when an access is accepted. Later changes at the inputs have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Access request |
| addr | input | 2*BUS_W | Full address |
| wr_data | input | MAX_BEATS*BUS_W | Write beats, beat 0 in the low bits |
| beat_cnt | input | BEAT_W | Number of beats minus one |
| adv1_on | input | ON_W | Address valid, first assert cycle |
| adv1_off | input | OFF_W | Address valid, first release cycle |
| adv2_on | input | ON_W | Address valid, second assert cycle |
| adv2_off | input | OFF_W | Address valid, second release cycle |
| oe1_on | input | ON_W | Output enable, first assert cycle |
| oe1_off | input | OFF_W | Output enable, first release cycle (also ends the upper address half) |
| oe2_on | input | ON_W | Output enable, second assert cycle |
| oe2_off | input | OFF_W | Output enable, second release cycle |
| we_on | input | ON_W | Write enable assert cycle (ends the address phase) |
| we_off | input | OFF_W | Write enable release cycle |
| data_on | input | ON_W | First data beat cycle |
| beat_gap | input | PG_W | Cycles between beats |
| cyc_time | input | CYC_W | Total access length in cycles |
| busy | output | 1 | Access in progress |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| dir_o | output | 1 | Bus direction, 1 = outward |
| bus_oe | output | 1 | Shared bus drive enable |
| bus_o | output | BUS_W | Shared bus value |

## Verification
The bench uses the default parameters: a 16-bit bus, 8 beats, 4-bit on fields, 5-bit off fields, a 4-bit beat interval and a 6-bit cycle count. With a cycle count of up to 63, all eight beats fit into one access when the interval is small. Larger intervals push later beats past the end of the access, so truncated bursts also occur. Off fields above 15 can exceed any on value, so both ordinary windows and inverted (empty) windows occur. Directed cases cover a zero cycle count, a zero beat interval, data that starts before write enable, a start held high through an access, and inputs scrambled right after acceptance.

// File: rtl/awm_pkg.sv
package awm_pkg;

   // Source selected for the shared bus in a given cycle.
   typedef enum logic [1:0] {
      SRC_ADDR_HI = 2'd0,
      SRC_ADDR_LO = 2'd1,
      SRC_DATA    = 2'd2
   } bus_src_e;

   // Strobe windows, in the order of the window array in the top.
   localparam int WIN_ADV1 = 0;
   localparam int WIN_ADV2 = 1;
   localparam int WIN_OE1  = 2;
   localparam int WIN_OE2  = 3;
   localparam int WIN_WE   = 4;
   localparam int NWIN     = 5;

endpackage

// File: rtl/awm_seq.sv
// Access sequencer: accepts a request, captures its context and runs the
// cycle counter until the programmed length is used up.
module awm_seq #(
   parameter int CYC_W = 6,
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CYC_W-1:0] cyc_time,
   input  logic [LAT_W-1:0] lat_in,
   output logic             busy,
   output logic [CYC_W-1:0] cnt,
   output logic [LAT_W-1:0] lat_q
);
   logic [CYC_W-1:0] cyc_q;
   logic [CYC_W-1:0] last_c;
   logic             busy_q;
   logic [CYC_W-1:0] cnt_q;

   always_comb last_c = (cyc_q == '0) ? '0 : cyc_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         cyc_q  <= '0;
         lat_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            cyc_q  <= cyc_time;
            lat_q  <= lat_in;
         end
      end else if (cnt_q == last_c) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy = busy_q;
   assign cnt  = cnt_q;
endmodule

// File: rtl/awm_window.sv
// One programmable strobe window: hit while on <= count < off during an access.
module awm_window #(
   parameter int ON_W  = 4,
   parameter int OFF_W = 5,
   parameter int CNT_W = 6
) (
   input  logic             busy,
   input  logic [CNT_W-1:0] cnt,
   input  logic [ON_W-1:0]  on_t,
   input  logic [OFF_W-1:0] off_t,
   output logic             hit
);
   localparam int CW0 = (ON_W > OFF_W) ? ON_W : OFF_W;
   localparam int CW  = ((CNT_W > CW0) ? CNT_W : CW0) + 1;

   logic [CW-1:0] c_x, on_x, off_x;

   always_comb begin
      c_x   = CW'(cnt);
      on_x  = CW'(on_t);
      off_x = CW'(off_t);
      hit   = busy && (c_x >= on_x) && (c_x < off_x);
   end
endmodule

// File: rtl/awm_busmux.sv
// Shared bus source selection: two address halves, then paced data beats,
// with the last driven value kept while idle.
module awm_busmux
   import awm_pkg::*;
#(
   parameter int BUS_W     = 16,
   parameter int MAX_BEATS = 8,
   parameter int BEAT_W    = 3,
   parameter int ON_W      = 4,
   parameter int OFF_W     = 5,
   parameter int PG_W      = 4,
   parameter int CNT_W     = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       busy,
   input  logic [CNT_W-1:0]           cnt,
   input  logic [2*BUS_W-1:0]         addr,
   input  logic [MAX_BEATS*BUS_W-1:0] data,
   input  logic [BEAT_W-1:0]          last_beat,
   input  logic [OFF_W-1:0]           hi_end,
   input  logic [ON_W-1:0]            we_on,
   input  logic [ON_W-1:0]            data_on,
   input  logic [PG_W-1:0]            gap,
   output logic [BUS_W-1:0]           bus_o
);
   localparam int SW0 = (CNT_W > OFF_W) ? CNT_W : OFF_W;
   localparam int SW  = SW0 + PG_W + BEAT_W + 2;

   logic [SW-1:0]          cnt_e, gap_e, don_e;
   logic [MAX_BEATS-1:0]   reached;
   logic [BEAT_W-1:0]      idx;
   bus_src_e               src;
   logic [BUS_W-1:0]       cur, hold_q;

   always_comb begin
      cnt_e = SW'(cnt);
      don_e = SW'(data_on);
      gap_e = (gap == '0) ? SW'(1) : SW'(gap);
   end

   for (genvar k = 0; k < MAX_BEATS; k++) begin : g_beat
      logic [SW-1:0] beat_start;
      always_comb begin
         beat_start = don_e + SW'(k) * gap_e;
         reached[k] = (SW'(k) <= SW'(last_beat)) && (cnt_e >= beat_start);
      end
   end

   always_comb begin
      idx = '0;
      for (int k = 0; k < MAX_BEATS; k++)
         if (reached[k]) idx = BEAT_W'(k);
   end

   always_comb begin
      if (cnt_e >= don_e)                src = SRC_DATA;
      else if (cnt_e >= SW'(we_on))      src = SRC_ADDR_LO;
      else if (cnt_e < SW'(hi_end))      src = SRC_ADDR_HI;
      else                               src = SRC_ADDR_LO;
   end

   always_comb begin
      case (src)
         SRC_ADDR_HI: cur = addr[2*BUS_W-1:BUS_W];
         SRC_ADDR_LO: cur = addr[BUS_W-1:0];
         default:     cur = data[idx*BUS_W +: BUS_W];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q <= '0;
      else if (busy) hold_q <= cur;
   end

   assign bus_o = busy ? cur : hold_q;
endmodule

// File: rtl/awm_wr_timer.sv
// Write access timing generator for a device with a shared address/data bus.
module awm_wr_timer
   import awm_pkg::*;
#(
   parameter int BUS_W     = 16,
   parameter int MAX_BEATS = 8,
   parameter int ON_W      = 4,
   parameter int OFF_W     = 5,
   parameter int PG_W      = 4,
   parameter int CYC_W     = 6,
   parameter int BEAT_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [2*BUS_W-1:0]         addr,
   input  logic [MAX_BEATS*BUS_W-1:0] wr_data,
   input  logic [BEAT_W-1:0]          beat_cnt,
   input  logic [ON_W-1:0]            adv1_on,
   input  logic [OFF_W-1:0]           adv1_off,
   input  logic [ON_W-1:0]            adv2_on,
   input  logic [OFF_W-1:0]           adv2_off,
   input  logic [ON_W-1:0]            oe1_on,
   input  logic [OFF_W-1:0]           oe1_off,
   input  logic [ON_W-1:0]            oe2_on,
   input  logic [OFF_W-1:0]           oe2_off,
   input  logic [ON_W-1:0]            we_on,
   input  logic [OFF_W-1:0]           we_off,
   input  logic [ON_W-1:0]            data_on,
   input  logic [PG_W-1:0]            beat_gap,
   input  logic [CYC_W-1:0]           cyc_time,
   output logic                       busy,
   output logic                       cs_n,
   output logic                       adv_n,
   output logic                       oe_n,
   output logic                       we_n,
   output logic                       dir_o,
   output logic                       bus_oe,
   output logic [BUS_W-1:0]           bus_o
);
   localparam int TIME_W = NWIN*(ON_W+OFF_W) + ON_W + PG_W;
   localparam int LAT_W  = 2*BUS_W + MAX_BEATS*BUS_W + BEAT_W + TIME_W;

   initial begin
      assert (BUS_W >= 1)                  else $fatal(1, "BUS_W must be positive");
      assert (MAX_BEATS >= 2)              else $fatal(1, "MAX_BEATS must be at least 2");
      assert ((1 << BEAT_W) >= MAX_BEATS)  else $fatal(1, "BEAT_W too narrow");
      assert (ON_W >= 1 && OFF_W >= ON_W)  else $fatal(1, "bad on/off widths");
      assert (CYC_W >= OFF_W)              else $fatal(1, "CYC_W narrower than OFF_W");
   end

   logic [LAT_W-1:0]           lat_in, lat_q;
   logic [CYC_W-1:0]           cnt;
   logic                       busy_i;

   logic [2*BUS_W-1:0]         addr_q;
   logic [MAX_BEATS*BUS_W-1:0] data_q;
   logic [BEAT_W-1:0]          beats_q;
   logic [ON_W-1:0]            on_q  [NWIN];
   logic [OFF_W-1:0]           off_q [NWIN];
   logic [ON_W-1:0]            don_q;
   logic [PG_W-1:0]            gap_q;
   logic [NWIN-1:0]            hit;

   assign lat_in = {addr, wr_data, beat_cnt,
                    adv1_on, adv1_off, adv2_on, adv2_off,
                    oe1_on,  oe1_off,  oe2_on,  oe2_off,
                    we_on,   we_off,   data_on, beat_gap};

   assign {addr_q, data_q, beats_q,
           on_q[WIN_ADV1], off_q[WIN_ADV1], on_q[WIN_ADV2], off_q[WIN_ADV2],
           on_q[WIN_OE1],  off_q[WIN_OE1],  on_q[WIN_OE2],  off_q[WIN_OE2],
           on_q[WIN_WE],   off_q[WIN_WE],   don_q, gap_q} = lat_q;

   awm_seq #(.CYC_W(CYC_W), .LAT_W(LAT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cyc_time (cyc_time),
      .lat_in   (lat_in),
      .busy     (busy_i),
      .cnt      (cnt),
      .lat_q    (lat_q)
   );

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      awm_window #(.ON_W(ON_W), .OFF_W(OFF_W), .CNT_W(CYC_W)) u_win (
         .busy  (busy_i),
         .cnt   (cnt),
         .on_t  (on_q[w]),
         .off_t (off_q[w]),
         .hit   (hit[w])
      );
   end

   awm_busmux #(
      .BUS_W(BUS_W), .MAX_BEATS(MAX_BEATS), .BEAT_W(BEAT_W),
      .ON_W(ON_W), .OFF_W(OFF_W), .PG_W(PG_W), .CNT_W(CYC_W)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy_i),
      .cnt       (cnt),
      .addr      (addr_q),
      .data      (data_q),
      .last_beat (beats_q),
      .hi_end    (off_q[WIN_OE1]),
      .we_on     (on_q[WIN_WE]),
      .data_on   (don_q),
      .gap       (gap_q),
      .bus_o     (bus_o)
   );

   assign busy   = busy_i;
   assign cs_n   = !busy_i;
   assign dir_o  = busy_i;
   assign bus_oe = busy_i;
   assign adv_n  = !(hit[WIN_ADV1] || hit[WIN_ADV2]);
   assign oe_n   = !(hit[WIN_OE1]  || hit[WIN_OE2]);
   assign we_n   = !hit[WIN_WE];
endmodule

// File: rtl/awm_wr_timer_chk.sv
// Temporal checks on the timing generator's ports.
module awm_wr_timer_chk #(
   parameter int BUS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             cs_n,
   input logic             adv_n,
   input logic             oe_n,
   input logic             we_n,
   input logic             dir_o,
   input logic             bus_oe,
   input logic [BUS_W-1:0] bus_o
);
   AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);                                       // R1
   AST_ACCESS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!cs_n && dir_o && bus_oe));                      // R3
   AST_ADV_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_n |-> busy);                                                 // R4
   AST_OE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> busy);                                                  // R5
   AST_WE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> busy);                                                  // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(bus_o));                      // R9
endmodule

bind awm_wr_timer awm_wr_timer_chk #(.BUS_W(BUS_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .cs_n   (cs_n),
   .adv_n  (adv_n),
   .oe_n   (oe_n),
   .we_n   (we_n),
   .dir_o  (dir_o),
   .bus_oe (bus_oe),
   .bus_o  (bus_o)
);

// File: tb/awm_wr_timer_test.sv
module awm_wr_timer_test;
   localparam int BUS_W = 16;
   localparam int NB    = 8;
   localparam int BW    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              start = 1'b0;
   logic [2*BUS_W-1:0] addr = '0;
   logic [NB*BUS_W-1:0] wr_data = '0;
   logic [BW-1:0]     beat_cnt = '0;
   logic [3:0] adv1_on = '0, adv2_on = '0, oe1_on = '0, oe2_on = '0, we_on = '0, data_on = '0;
   logic [4:0] adv1_off = '0, adv2_off = '0, oe1_off = '0, oe2_off = '0, we_off = '0;
   logic [3:0] beat_gap = '0;
   logic [5:0] cyc_time = '0;
   logic busy, cs_n, adv_n, oe_n, we_n, dir_o, bus_oe;
   logic [BUS_W-1:0] bus_o;

   awm_wr_timer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wr_data(wr_data),
      .beat_cnt(beat_cnt), .adv1_on(adv1_on), .adv1_off(adv1_off),
      .adv2_on(adv2_on), .adv2_off(adv2_off), .oe1_on(oe1_on), .oe1_off(oe1_off),
      .oe2_on(oe2_on), .oe2_off(oe2_off), .we_on(we_on), .we_off(we_off),
      .data_on(data_on), .beat_gap(beat_gap), .cyc_time(cyc_time),
      .busy(busy), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
      .dir_o(dir_o), .bus_oe(bus_oe), .bus_o(bus_o)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Saved copy of the access under test (bench-side expectation source).
   int s_on[5], s_off[5];          // 0 adv1, 1 adv2, 2 oe1, 3 oe2, 4 we
   int s_don, s_gap, s_cyc, s_len;
   logic [2*BUS_W-1:0] s_addr;
   logic [BUS_W-1:0] s_dat[NB];

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit win(int c, int on, int off);
      return (c >= on) && (c < off);
   endfunction

   function automatic int total_len();
      return (s_cyc == 0) ? 1 : s_cyc;
   endfunction

   function automatic logic [BUS_W-1:0] exp_bus(int c);
      int g, idx;
      if (c >= s_don) begin
         g = (s_gap == 0) ? 1 : s_gap;
         idx = 0;
         for (int k = 0; k <= s_len; k++)
            if (c >= s_don + k*g) idx = k;
         return s_dat[idx];
      end
      if (c >= s_on[4]) return s_addr[BUS_W-1:0];
      if (c < s_off[2]) return s_addr[2*BUS_W-1:BUS_W];
      return s_addr[BUS_W-1:0];
   endfunction

   task automatic drive_saved();
      addr = s_addr;
      for (int k = 0; k < NB; k++) wr_data[k*BUS_W +: BUS_W] = s_dat[k];
      beat_cnt = BW'(s_len);
      adv1_on = 4'(s_on[0]); adv1_off = 5'(s_off[0]);
      adv2_on = 4'(s_on[1]); adv2_off = 5'(s_off[1]);
      oe1_on  = 4'(s_on[2]); oe1_off  = 5'(s_off[2]);
      oe2_on  = 4'(s_on[3]); oe2_off  = 5'(s_off[3]);
      we_on   = 4'(s_on[4]); we_off   = 5'(s_off[4]);
      data_on = 4'(s_don); beat_gap = 4'(s_gap); cyc_time = 6'(s_cyc);
   endtask

   task automatic scramble();
      addr = $urandom; wr_data = {$urandom, $urandom, $urandom, $urandom};
      beat_cnt = BW'($urandom); cyc_time = 6'($urandom);
      adv1_on = 4'($urandom); adv1_off = 5'($urandom); adv2_on = 4'($urandom); adv2_off = 5'($urandom);
      oe1_on = 4'($urandom); oe1_off = 5'($urandom); oe2_on = 4'($urandom); oe2_off = 5'($urandom);
      we_on = 4'($urandom); we_off = 5'($urandom); data_on = 4'($urandom); beat_gap = 4'($urandom);
   endtask

   task automatic rand_cfg();
      for (int w = 0; w < 5; w++) begin
         s_on[w] = $urandom_range(0, 15);
         s_off[w] = $urandom_range(0, 31);
      end
      s_don = $urandom_range(0, 15); s_gap = $urandom_range(0, 15);
      s_cyc = $urandom_range(0, 63); s_len = $urandom_range(0, NB-1);
      s_addr = $urandom;
      for (int k = 0; k < NB; k++) s_dat[k] = BUS_W'($urandom);
   endtask

   task automatic run(input bit hold, input bit scr);
      int t;
      logic [BUS_W-1:0] lastv;
      @(negedge clk); drive_saved(); start = 1'b1;
      @(posedge clk); @(negedge clk);
      if (!hold) start = 1'b0;
      if (scr) scramble();                                      // R10
      t = total_len();
      for (int c = 0; c < t; c++) begin
         chk("R1", "busy", 32'(busy), 32'd1);
         chk("R3", "cs_n/dir/bus_oe", {29'd0, cs_n, dir_o, bus_oe}, 32'b011);
         chk("R4", "adv_n", 32'(adv_n), 32'(!(win(c, s_on[0], s_off[0]) || win(c, s_on[1], s_off[1]))));
         chk("R5", "oe_n", 32'(oe_n), 32'(!(win(c, s_on[2], s_off[2]) || win(c, s_on[3], s_off[3]))));
         chk("R6", "we_n", 32'(we_n), 32'(!win(c, s_on[4], s_off[4])));
         chk((c < s_don) ? "R7" : "R8", "bus_o", 32'(bus_o), 32'(exp_bus(c)));
         if (c == t-1) start = 1'b0;                            // R2 held start
         @(negedge clk);
      end
      lastv = exp_bus(t-1);
      chk(hold ? "R2" : "R1", "busy after end", 32'(busy), 32'd0);
      chk("R3", "cs_n/dir/bus_oe idle", {29'd0, cs_n, dir_o, bus_oe}, 32'b100);
      chk("R9", "idle bus", 32'(bus_o), 32'(lastv));
      addr = ~addr; wr_data = ~wr_data;
      @(negedge clk);
      chk("R9", "idle bus later", 32'(bus_o), 32'(lastv));
   endtask

   task automatic base_cfg();
      s_on[0] = 0;  s_off[0] = 2;       // first address-valid pulse
      s_on[1] = 3;  s_off[1] = 5;       // second address-valid pulse
      s_on[2] = 0;  s_off[2] = 3;       // upper half while oe low
      s_on[3] = 9;  s_off[3] = 10;
      s_on[4] = 6;  s_off[4] = 20;
      s_don = 8; s_gap = 3; s_len = 3; s_cyc = 24;
      s_addr = 32'hA5C3_1E7B;
      for (int k = 0; k < NB; k++) s_dat[k] = BUS_W'(16'h1000 + k*16'h0111);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // reset state
      chk("R1", "reset busy", 32'(busy), 32'd0);
      chk("R3", "reset cs_n/dir/bus_oe", {29'd0, cs_n, dir_o, bus_oe}, 32'b100);
      chk("R4", "reset strobes", {29'd0, adv_n, oe_n, we_n}, 32'b111);
      chk("R9", "reset bus", 32'(bus_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // directed: typical ordering
      base_cfg(); run(1'b0, 1'b0);
      // zero cycle count gives one-cycle access
      base_cfg(); s_cyc = 0; run(1'b0, 1'b0);
      // empty windows (on >= off), zero gap, data before write enable
      base_cfg(); s_on[0] = 5; s_off[0] = 5; s_on[4] = 12; s_off[4] = 4;
      s_gap = 0; s_don = 2; s_len = 7; s_cyc = 15; run(1'b0, 1'b0);
      // start held high through access (R2)
      base_cfg(); run(1'b1, 1'b0);
      // inputs scrambled after acceptance (R10)
      base_cfg(); s_len = 7; s_gap = 1; run(1'b0, 1'b1);
      // constrained random mix
      for (int i = 0; i < 80; i++) begin
         rand_cfg();
         run(i % 7 == 3, i % 5 == 1);
      end
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule